// File: doc/BRIEF.md
# Stop-Mode Wakeup and Clock Stabilization Controller

This block brings a processor back out of a low-power stop state. A stop request from the core halts the main oscillator. In PLL stop mode it also halts the frequency multiplier. The block then watches external interrupt requests. A request whose priority is high enough cancels the stop state and starts one stabilization wait, counted on the reference clock. The wait length comes from a 2-bit select field that is latched when stop is entered.

When the wait has elapsed, the block raises its clock-ready output. It then makes one decision for the core. If the global interrupt enable is set and the most urgent pending level passes the level mask, it pulses a take-interrupt strobe with that level. Otherwise it pulses a resume strobe, and the core continues at the instruction after the one that entered stop. The controller then returns to normal run.

In PLL stop mode, the oscillator and the multiplier settle in parallel under the same single wait. For that reason PLL stop may only be entered with one of the two longest wait settings. A request for PLL stop with a shorter setting is refused and leaves a sticky error flag.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While stopped, only a valid request with `irqLevel` numerically below 7 (all ones) ends the stop state. A request at level 7 leaves the controller stopped, with `clkReady` and `mainClkRun` low.
- R2: `mainClkRun` is low only in the stopped state. `pllRun` is low only in the stopped state when PLL stop was entered (`pllMode`=1). Both are high while waiting, deciding and running.
- R3: After a wake, `clkReady` stays low for exactly 2^10, 2^13, 2^14 or 2^15 cycles, for a latched `waitSel` of 2'b00, 2'b01, 2'b10 or 2'b11. `clkReady` is high in run and in the decide cycle.
- R4: In PLL stop mode the wait is one shared wait. For equal `waitSel` it has the same length as in main stop mode, with no second wait added.
- R5: A `stopReq` with `pllMode`=1 and `waitSel` 2'b00 or 2'b01 is refused. The controller stays in run with both clocks enabled.
- R6: `cfgError` is low after reset, goes high on a refused PLL stop request, and stays high until reset.
- R7: The evaluated level is the lowest value among the waking request and every valid request seen during the wait, including one in the last wait cycle.
- R8: In the decide cycle, `takeIntStb` pulses with `takeLevel` equal to the evaluated level when `intEnable`=1 and the level is numerically below `levelMask`. Otherwise `resumeStb` pulses. Exactly one of the two strobes is high, for one cycle, and the next cycle is run.
- R9: After reset the controller is in run, with `clkReady`, `mainClkRun` and `pllRun` high, both strobes low and `cfgError` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stopReq | input | 1 | One-cycle request to enter stop |
| pllMode | input | 1 | 0 = main stop, 1 = PLL stop |
| waitSel | input | 2 | Stabilization wait select, latched on stop entry |
| irqValid | input | 1 | External interrupt request present |
| irqLevel | input | 3 | Priority level of the request (0 is most urgent) |
| intEnable | input | 1 | Global interrupt enable flag |
| levelMask | input | 3 | Level mask; a level passes when numerically lower |
| mainClkRun | output | 1 | Main oscillator run enable |
| pllRun | output | 1 | Multiplier run enable |
| clkReady | output | 1 | Clock stable, core may execute |
| resumeStb | output | 1 | Resume at the next instruction |
| takeIntStb | output | 1 | Branch to the interrupt routine |
| takeLevel | output | 3 | Level being taken, valid with `takeIntStb` |
| cfgError | output | 1 | Sticky flag for a refused PLL stop request |

## Verification
The functions that can land in the same cycle are the end of the stabilization count and the capture of a new request. A request that arrives in the last wait cycle must still be part of the decision taken in the very next cycle.

The bench provokes this by counting the low cycles of `clkReady` and raising a more urgent request exactly in the final one. The waking level alone would fail the mask, so only a correctly merged late request yields `takeIntStb` with the late level. A request raised mid-wait and a less urgent late request check the merge in its other orderings.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DECIDE = 2'd3
  } wakeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enterStop;  // latch mode and wait select
    logic wakeLoad;   // clear counter, seed pending level
    logic waitTick;   // advance stabilization counter
    logic collect;    // merge incoming requests into pending level
    logic setErr;     // record refused PLL stop entry
  } ctrlStrb_t;

endpackage

// File: rtl/stop_wake_dp.sv
module stop_wake_dp
  import stop_wake_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int EXP0  = 10,
  parameter int EXP1  = 13,
  parameter int EXP2  = 14,
  parameter int EXP3  = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        ctrl,
  input  logic [1:0]       waitSel,
  input  logic             pllMode,
  input  logic             irqValid,
  input  logic [LVL_W-1:0] irqLevel,
  output logic             waitDone,
  output logic [LVL_W-1:0] pendLevel,
  output logic             pllLatched,
  output logic             cfgError
);

  localparam int EXP_A   = (EXP0 > EXP1) ? EXP0 : EXP1;
  localparam int EXP_B   = (EXP2 > EXP3) ? EXP2 : EXP3;
  localparam int EXP_MAX = (EXP_A > EXP_B) ? EXP_A : EXP_B;
  localparam int CNT_W   = EXP_MAX;
  localparam int EXPS [4] = '{EXP0, EXP1, EXP2, EXP3};

  logic [CNT_W-1:0] lastTbl [4];
  logic [CNT_W-1:0] waitCnt;
  logic [1:0]       selReg;

  // terminal count per wait setting: 2^EXPn - 1
  for (genvar g = 0; g < 4; g++) begin : g_last
    assign lastTbl[g] = CNT_W'((64'd1 << EXPS[g]) - 64'd1);
  end

  assign waitDone = (waitCnt == lastTbl[selReg]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg     <= 2'b00;
      pllLatched <= 1'b0;
    end else if (ctrl.enterStop) begin
      selReg     <= waitSel;
      pllLatched <= pllMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitCnt <= '0;
    else if (ctrl.wakeLoad) waitCnt <= '0;
    else if (ctrl.waitTick) waitCnt <= waitCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pendLevel <= '1;
    else if (ctrl.wakeLoad)
      pendLevel <= irqLevel;
    else if (ctrl.collect && irqValid && (irqLevel < pendLevel))
      pendLevel <= irqLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgError <= 1'b0;
    else if (ctrl.setErr) cfgError <= 1'b1;
  end

  // R3: counter never runs past the selected terminal count
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.waitTick |-> (waitCnt < lastTbl[selReg]));

  // R5: a latched PLL stop always carries one of the two long waits
  assert_pll_long_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    pllLatched |-> selReg[1]);

  // R6: error flag is sticky
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  // R7: pending level only moves toward higher priority during the wait
  assert_pend_mono_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.collect && !ctrl.wakeLoad) |=> (pendLevel <= $past(pendLevel)));

endmodule

// File: rtl/stop_wake_fsm.sv
module stop_wake_fsm
  import stop_wake_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic             pllMode,
  input  logic             waitSelHi,
  input  logic             irqValid,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic             intEnable,
  input  logic [LVL_W-1:0] levelMask,
  input  logic             waitDone,
  input  logic [LVL_W-1:0] pendLevel,
  input  logic             pllLatched,
  output ctrlStrb_t        ctrl,
  output logic             mainClkRun,
  output logic             pllRun,
  output logic             clkReady,
  output logic             resumeStb,
  output logic             takeIntStb
);

  wakeState_t state, stateNxt;
  logic wakeOk, refuse, accept;

  assign wakeOk = irqValid && (irqLevel != {LVL_W{1'b1}});
  assign refuse = pllMode && !waitSelHi;
  assign accept = intEnable && (pendLevel < levelMask);

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    unique case (state)
      ST_RUN: begin
        if (stopReq && !refuse) begin
          ctrl.enterStop = 1'b1;
          stateNxt       = ST_STOP;
        end
        ctrl.setErr = stopReq && refuse;
      end
      ST_STOP: begin
        if (wakeOk) begin
          ctrl.wakeLoad = 1'b1;
          stateNxt      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        ctrl.collect = 1'b1;
        if (waitDone) stateNxt      = ST_DECIDE;
        else          ctrl.waitTick = 1'b1;
      end
      ST_DECIDE: stateNxt = ST_RUN;
      default:   stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  assign clkReady   = (state == ST_RUN) || (state == ST_DECIDE);
  assign mainClkRun = (state != ST_STOP);
  assign pllRun     = !((state == ST_STOP) && pllLatched);
  assign resumeStb  = (state == ST_DECIDE) && !accept;
  assign takeIntStb = (state == ST_DECIDE) && accept;

  // R1: a level-7 or absent request leaves the controller stopped
  assert_lvl7_stays_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_STOP) && (!irqValid || (irqLevel == {LVL_W{1'b1}}))) |=> (state == ST_STOP));

  // R2: clock-ready implies the main oscillator runs
  assert_ready_clk_R2: assert property (@(posedge clk) disable iff (!rstN)
    clkReady |-> (mainClkRun && pllRun));

  // R5: a refused PLL stop request keeps the controller running
  assert_refuse_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN) && stopReq && pllMode && !waitSelHi) |=> (state == ST_RUN));

  // R8: exactly one strobe in decide, and decide lasts one cycle
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE) |-> (resumeStb ^ takeIntStb));
  assert_decide_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE) |=> ((state == ST_RUN) && !resumeStb && !takeIntStb));

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stop_wake_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int EXP0  = 10,
  parameter int EXP1  = 13,
  parameter int EXP2  = 14,
  parameter int EXP3  = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic             pllMode,
  input  logic [1:0]       waitSel,
  input  logic             irqValid,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic             intEnable,
  input  logic [LVL_W-1:0] levelMask,
  output logic             mainClkRun,
  output logic             pllRun,
  output logic             clkReady,
  output logic             resumeStb,
  output logic             takeIntStb,
  output logic [LVL_W-1:0] takeLevel,
  output logic             cfgError
);

  ctrlStrb_t        ctrl;
  logic             waitDone;
  logic             pllLatched;
  logic [LVL_W-1:0] pendLevel;

  stop_wake_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .pllMode    (pllMode),
    .waitSelHi  (waitSel[1]),
    .irqValid   (irqValid),
    .irqLevel   (irqLevel),
    .intEnable  (intEnable),
    .levelMask  (levelMask),
    .waitDone   (waitDone),
    .pendLevel  (pendLevel),
    .pllLatched (pllLatched),
    .ctrl       (ctrl),
    .mainClkRun (mainClkRun),
    .pllRun     (pllRun),
    .clkReady   (clkReady),
    .resumeStb  (resumeStb),
    .takeIntStb (takeIntStb)
  );

  stop_wake_dp #(
    .LVL_W(LVL_W), .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .waitSel    (waitSel),
    .pllMode    (pllMode),
    .irqValid   (irqValid),
    .irqLevel   (irqLevel),
    .waitDone   (waitDone),
    .pendLevel  (pendLevel),
    .pllLatched (pllLatched),
    .cfgError   (cfgError)
  );

  assign takeLevel = pendLevel;

endmodule

// File: tb/stop_wake_ctrl_tb.sv
module stop_wake_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN, stopReq, pllMode, irqValid, intEnable;
  logic [1:0] waitSel;
  logic [2:0] irqLevel, levelMask;
  logic       mainClkRun, pllRun, clkReady, resumeStb, takeIntStb, cfgError;
  logic [2:0] takeLevel;

  always #5 clk = ~clk;

  stop_wake_ctrl u_dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .pllMode(pllMode),
    .waitSel(waitSel), .irqValid(irqValid), .irqLevel(irqLevel),
    .intEnable(intEnable), .levelMask(levelMask), .mainClkRun(mainClkRun),
    .pllRun(pllRun), .clkReady(clkReady), .resumeStb(resumeStb),
    .takeIntStb(takeIntStb), .takeLevel(takeLevel), .cfgError(cfgError)
  );

  typedef struct {
    bit       take;
    bit [2:0] lvl;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int waitLen(input bit [1:0] sel);
    case (sel)
      2'b00:   return 1 << 10;
      2'b01:   return 1 << 13;
      2'b10:   return 1 << 14;
      default: return 1 << 15;
    endcase
  endfunction

  // monitor: pop one expected decision per strobe
  always @(negedge clk) begin
    if (rstN === 1'b1 && (resumeStb || takeIntStb)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8", "strobe with empty scoreboard", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(resumeStb ^ takeIntStb, "R8", "exactly one strobe",
              int'(resumeStb) + int'(takeIntStb), 1);
        check(takeIntStb == e.take, "R8", "take decision", int'(takeIntStb), int'(e.take));
        if (e.take)
          check(takeLevel == e.lvl, "R7", "taken level", int'(takeLevel), int'(e.lvl));
      end
    end
  end

  // driver: one full stop / wake / decide sequence
  task automatic wakeSeq(input bit pll, input bit [1:0] sel, input bit [2:0] wLvl,
                         input bit midEn, input bit [2:0] midLvl,
                         input bit lateEn, input bit [2:0] lateLvl,
                         input bit ien, input bit [2:0] mask);
    int expN;
    int n;
    bit [2:0] pend;
    expItem_t e;
    expN = waitLen(sel);
    pend = wLvl;
    if (midEn && midLvl < pend)   pend = midLvl;
    if (lateEn && lateLvl < pend) pend = lateLvl;
    e.take = ien && (pend < mask);
    e.lvl  = pend;
    intEnable = ien;
    levelMask = mask;
    pllMode = pll;
    waitSel = sel;
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check(clkReady == 1'b0, "R3", "ready low in stop", int'(clkReady), 0);
    check(mainClkRun == 1'b0, "R2", "main clock off in stop", int'(mainClkRun), 0);
    check(pllRun == !pll, "R2", "pll enable in stop", int'(pllRun), int'(!pll));
    // level 7 must not wake (R1)
    irqValid = 1'b1;
    irqLevel = 3'd7;
    repeat (3) @(negedge clk);
    check(!clkReady && !mainClkRun, "R1", "level 7 wakes",
          int'(mainClkRun), 0);
    expQ.push_back(e);
    irqLevel = wLvl;
    @(negedge clk);
    irqValid = 1'b0;
    n = 0;
    while (!clkReady && n < 40000) begin
      n++;
      if (n == 1)
        check(mainClkRun && pllRun, "R2", "clocks run in wait",
              int'(mainClkRun) + int'(pllRun), 2);
      irqValid = 1'b0;
      if (midEn && n == 2) begin
        irqValid = 1'b1; irqLevel = midLvl;
      end
      if (lateEn && n == expN) begin
        irqValid = 1'b1; irqLevel = lateLvl;
      end
      @(negedge clk);
    end
    irqValid = 1'b0;
    if (pll) check(n == expN, "R4", "shared pll wait length", n, expN);
    else     check(n == expN, "R3", "main wait length", n, expN);
    @(negedge clk);
    check(clkReady && !resumeStb && !takeIntStb, "R8", "back in run after decide",
          int'(clkReady), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 200000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; stopReq = 1'b0; pllMode = 1'b0; waitSel = 2'b00;
    irqValid = 1'b0; irqLevel = 3'd0; intEnable = 1'b0; levelMask = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(clkReady && mainClkRun && pllRun, "R9", "clocks after reset",
          int'(clkReady) + int'(mainClkRun) + int'(pllRun), 3);
    check(!resumeStb && !takeIntStb, "R9", "strobes after reset",
          int'(resumeStb) + int'(takeIntStb), 0);
    check(cfgError == 1'b0, "R9", "error after reset", int'(cfgError), 0);

    // R8 take: level 3 below mask 5
    wakeSeq(1'b0, 2'b00, 3'd3, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd5);
    // R8 resume: interrupts disabled
    wakeSeq(1'b0, 2'b00, 3'd4, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd7);
    // R8 mask boundary: level equal to mask resumes
    wakeSeq(1'b0, 2'b00, 3'd4, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd4);
    // R7 mid-wait higher priority, later lower priority ignored
    wakeSeq(1'b0, 2'b00, 3'd5, 1'b1, 3'd2, 1'b1, 3'd6, 1'b1, 3'd7);
    // R7 collision: more urgent request in the last wait cycle
    wakeSeq(1'b0, 2'b00, 3'd5, 1'b0, 3'd0, 1'b1, 3'd1, 1'b1, 3'd3);
    // R3 select 01
    wakeSeq(1'b0, 2'b01, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd7);

    // R5 / R6 refusal of PLL stop with short waits
    for (int s = 0; s < 2; s++) begin
      pllMode = 1'b1;
      waitSel = 2'(s);
      stopReq = 1'b1;
      @(negedge clk);
      stopReq = 1'b0;
      check(clkReady && mainClkRun && pllRun, "R5", "refused pll stop stays in run",
            int'(clkReady) + int'(mainClkRun) + int'(pllRun), 3);
      check(cfgError == 1'b1, "R6", "error set on refusal", int'(cfgError), 1);
      repeat (2) @(negedge clk);
      check(clkReady == 1'b1, "R5", "still running later", int'(clkReady), 1);
    end

    // R4 PLL stop with both long waits, then main with select 10
    wakeSeq(1'b1, 2'b10, 3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd6);
    wakeSeq(1'b1, 2'b11, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd7);
    wakeSeq(1'b0, 2'b10, 3'd1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd1);

    check(cfgError == 1'b1, "R6", "error sticky after wakes", int'(cfgError), 1);
    check(expQ.size() == 0, "R8", "all decisions observed", expQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule